// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Writer

This block takes packets that arrive as a byte stream and places them into host memory. Where each packet goes is set by a ring of two-word descriptors, which also live in host memory. For each packet, the block reads the descriptor at its current pointer and checks that software has handed the descriptor over. It then copies bytes into that descriptor's buffer. When a packet is longer than one buffer, the block moves on to the following descriptor. The step to the following descriptor is eight bytes forward, unless the current descriptor carries a wrap flag; in that case the walk returns to the ring base. Each descriptor used is written back with its ownership released, its continuation flag and the number of bytes actually stored.

Software programs the ring base and the current-descriptor pointer through a small register port while the engine is idle. From then on, the engine keeps the current pointer up to date by itself. A packet that finds its first descriptor still held by software is consumed and discarded whole. A packet that runs into a held descriptor partway through keeps the part already stored and loses the rest. Both cases count as one drop.

The byte input is a valid/ready stream. The source must keep `s_valid`, `s_data` and `s_last` steady until a cycle in which `s_ready` is high. `s_ready` stays low while descriptors are fetched or written back, and it also stays low while a buffer write waits for memory. The memory port is a plain request/acknowledge master: a request holds its address, direction and data until the acknowledge.

Top module: `rxrw_top`

## Requirements
- R1: Register offset 0x04 reads and writes the ring base, offset 0x08 reads and writes the current-descriptor pointer, and any other offset reads zero. Writes take effect only while the engine is idle. Both registers reset to zero.
- R2: A descriptor is two 32-bit words. Word 0 sits at the descriptor address and word 1 at the address plus 4. In word 0, bit 31 means owned by the engine, bit 30 means wrap, bit 27 means continues, and bits 12:0 give the buffer length. Word 1 is the buffer address. Descriptor reads and writes use all four byte lanes (`mem_be` = 4'hF) at word-aligned addresses.
- R3: Packet byte i within a buffer is written to buffer address + i, one byte per write. Each byte write enables only the lane selected by address bits 1:0, with the byte copied to all four lanes. A buffer receives the smaller of its length and the bytes still left in the packet.
- R4: When a buffer is full and more bytes follow, the next descriptor is at the ring base if the full descriptor has wrap set, and at its address plus 8 otherwise.
- R5: Every descriptor used is written back with bit 31 cleared and bits 12:0 set to the bytes stored. Bit 27 is set on all but the last descriptor of the packet, and the other word-0 bits are kept. Word 1 is never written.
- R6: After a packet is stored, the current-descriptor pointer holds the descriptor that follows the last one used.
- R7: If the first descriptor is not owned, the whole packet is accepted and discarded and the drop count rises by one. The pointer, the descriptor and the buffers are left unchanged.
- R8: If a chained descriptor is not owned, the previous descriptor is written back with continues clear and its full length. The pointer moves to the unowned descriptor, the rest of the packet is discarded, and the drop count rises by one.
- R9: `s_ready` is low while a descriptor is being fetched, so the first byte of a packet is accepted no earlier than the fourth rising edge after `s_valid` rises in idle.
- R10: A memory request that is not acknowledged keeps its request, address and direction on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe (honoured when idle) |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream byte accepted this cycle |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Final byte of the packet |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Memory byte-lane enables |
| mem_ack | input | 1 | Memory acknowledge, completes the request |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| drop_cnt | output | 16 | Count of dropped or truncated packets |

## Verification
Some properties are checked on every cycle: request stability while the memory stalls, the one-lane rule for buffer writes, word alignment of descriptor accesses, cleared ownership in every descriptor write-back, and a drop count that only ever steps by one. The scenarios cover the rest. Those are the byte placement, the split of a packet across buffers, the wrap back to the ring base, the exact write-back words, the final pointer position, and the two ways a packet is lost. None of these can be seen from a single cycle.

// File: rtl/rxrw_pkg.sv
package rxrw_pkg;
  localparam int OWN_BIT  = 31;
  localparam int WRAP_BIT = 30;
  localparam int CONT_BIT = 27;

  localparam logic [7:0] OFS_BASE = 8'h04;
  localparam logic [7:0] OFS_CUR  = 8'h08;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH0,
    ST_FETCH1,
    ST_FILL,
    ST_PEEK,
    ST_WBACK,
    ST_DROP
  } eng_state_t;

  typedef enum logic [1:0] {
    WB_END,
    WB_CHAIN,
    WB_TRUNC
  } wb_kind_t;
endpackage

// File: rtl/rxrw_regs.sv
module rxrw_regs
  import rxrw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [7:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          idle,
  input  logic          cur_ld,
  input  logic [AW-1:0] cur_nxt,
  output logic [AW-1:0] ring_base,
  output logic [AW-1:0] cur_ptr
);
  logic sw_wr;
  assign sw_wr = reg_we && idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ring_base <= '0;
      cur_ptr   <= '0;
    end else begin
      if (sw_wr && reg_addr == OFS_BASE) ring_base <= reg_wdata[AW-1:0];
      if (cur_ld)
        cur_ptr <= cur_nxt;
      else if (sw_wr && reg_addr == OFS_CUR)
        cur_ptr <= reg_wdata[AW-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_BASE: reg_rdata[AW-1:0] = ring_base;
      OFS_CUR:  reg_rdata[AW-1:0] = cur_ptr;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rxrw_engine.sv
module rxrw_engine
  import rxrw_pkg::*;
#(
  parameter int AW     = 32,
  parameter int LEN_W  = 13,
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  input  logic [7:0]        s_data,
  input  logic              s_last,
  output logic              s_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  input  logic [AW-1:0]     ring_base,
  input  logic [AW-1:0]     cur_ptr,
  output logic              cur_ld,
  output logic [AW-1:0]     cur_nxt,
  output logic              idle,
  output logic [DROP_W-1:0] drop_cnt
);
  localparam logic [AW-1:0] DESC_STEP = AW'(8);
  localparam logic [AW-1:0] WORD1_OFS = AW'(4);

  eng_state_t        st;
  wb_kind_t          wbk;
  logic [31:0]       w0;
  logic [31:0]       nw0;
  logic [AW-1:0]     buf_ptr;
  logic [LEN_W-1:0]  cnt;
  logic [LEN_W-1:0]  cap;
  logic              full;
  logic [AW-1:0]     nxt_addr;
  logic [AW-1:0]     byte_addr;
  logic [31:0]       wb_word;

  assign cap       = w0[LEN_W-1:0];
  assign full      = (cnt == cap);
  assign nxt_addr  = w0[WRAP_BIT] ? ring_base : cur_ptr + DESC_STEP;
  assign byte_addr = buf_ptr + AW'(cnt);
  assign idle      = (st == ST_IDLE);
  assign cur_nxt   = nxt_addr;
  assign cur_ld    = (st == ST_WBACK) && mem_ack;

  always_comb begin
    wb_word = w0;
    wb_word[OWN_BIT]     = 1'b0;
    wb_word[CONT_BIT]    = (wbk == WB_CHAIN);
    wb_word[LEN_W-1:0]   = cnt;
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_ptr;
    mem_wdata = '0;
    mem_be    = 4'hF;
    s_ready   = 1'b0;
    case (st)
      ST_FETCH0: mem_req = 1'b1;
      ST_FETCH1: begin
        mem_req  = 1'b1;
        mem_addr = cur_ptr + WORD1_OFS;
      end
      ST_FILL: begin
        mem_req   = s_valid && !full;
        mem_we    = 1'b1;
        mem_addr  = byte_addr;
        mem_wdata = {4{s_data}};
        mem_be    = 4'b0001 << byte_addr[1:0];
        s_ready   = mem_req && mem_ack;
      end
      ST_PEEK: begin
        mem_req  = 1'b1;
        mem_addr = nxt_addr;
      end
      ST_WBACK: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = wb_word;
      end
      ST_DROP: s_ready = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      wbk      <= WB_END;
      w0       <= '0;
      nw0      <= '0;
      buf_ptr  <= '0;
      cnt      <= '0;
      drop_cnt <= '0;
    end else begin
      case (st)
        ST_IDLE: if (s_valid) st <= ST_FETCH0;
        ST_FETCH0: if (mem_ack) begin
          if (mem_rdata[OWN_BIT]) begin
            w0 <= mem_rdata;
            st <= ST_FETCH1;
          end else begin
            st <= ST_DROP;
          end
        end
        ST_FETCH1: if (mem_ack) begin
          buf_ptr <= mem_rdata[AW-1:0];
          cnt     <= '0;
          st      <= ST_FILL;
        end
        ST_FILL: begin
          if (full && s_valid) begin
            st <= ST_PEEK;
          end else if (s_ready) begin
            cnt <= cnt + 1'b1;
            if (s_last) begin
              wbk <= WB_END;
              st  <= ST_WBACK;
            end
          end
        end
        ST_PEEK: if (mem_ack) begin
          nw0 <= mem_rdata;
          wbk <= mem_rdata[OWN_BIT] ? WB_CHAIN : WB_TRUNC;
          st  <= ST_WBACK;
        end
        ST_WBACK: if (mem_ack) begin
          case (wbk)
            WB_CHAIN: begin
              w0 <= nw0;
              st <= ST_FETCH1;
            end
            WB_TRUNC: st <= ST_DROP;
            default:  st <= ST_IDLE;
          endcase
        end
        ST_DROP: if (s_valid && s_last) begin
          drop_cnt <= drop_cnt + 1'b1;
          st       <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxrw_top.sv
module rxrw_top
  import rxrw_pkg::*;
#(
  parameter int AW     = 32,
  parameter int LEN_W  = 13,
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [7:0]        s_data,
  input  logic              s_last,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic [DROP_W-1:0] drop_cnt
);
  logic          idle;
  logic          cur_ld;
  logic [AW-1:0] cur_nxt;
  logic [AW-1:0] ring_base;
  logic [AW-1:0] cur_ptr;

  rxrw_regs #(.AW(AW)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .idle      (idle),
    .cur_ld    (cur_ld),
    .cur_nxt   (cur_nxt),
    .ring_base (ring_base),
    .cur_ptr   (cur_ptr)
  );

  rxrw_engine #(.AW(AW), .LEN_W(LEN_W), .DROP_W(DROP_W)) eng_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_valid   (s_valid),
    .s_data    (s_data),
    .s_last    (s_last),
    .s_ready   (s_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_be    (mem_be),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .ring_base (ring_base),
    .cur_ptr   (cur_ptr),
    .cur_ld    (cur_ld),
    .cur_nxt   (cur_nxt),
    .idle      (idle),
    .drop_cnt  (drop_cnt)
  );
endmodule

// File: rtl/rxrw_sva.sv
module rxrw_sva #(
  parameter int AW     = 32,
  parameter int DROP_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_we,
  input logic [AW-1:0]     mem_addr,
  input logic [31:0]       mem_wdata,
  input logic [3:0]        mem_be,
  input logic              mem_ack,
  input logic [DROP_W-1:0] drop_cnt
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10

  AST_BYTE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_be != 4'hF) |-> $onehot(mem_be)); // R3

  AST_DESC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_be == 4'hF) |-> (mem_addr[1:0] == 2'b00)); // R2

  AST_WB_OWN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_be == 4'hF) |-> !mem_wdata[31]); // R5

  AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((drop_cnt == $past(drop_cnt)) || (drop_cnt == $past(drop_cnt) + 1'b1))); // R7
endmodule

bind rxrw_top rxrw_sva #(.AW(AW), .DROP_W(DROP_W)) sva_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_be    (mem_be),
  .mem_ack   (mem_ack),
  .drop_cnt  (drop_cnt)
);

// File: tb/rxrw_top_tb_top.sv
`timescale 1ns/1ps
module rxrw_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [7:0]  s_data = '0;
  logic        s_last = 1'b0;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic [15:0] drop_cnt;

  always #2 clk = ~clk;

  rxrw_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .s_last(s_last), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .drop_cnt(drop_cnt)
  );

  // host memory model, 512 bytes, acknowledge stalls on a fixed pattern
  logic [7:0] mem [0:511];
  logic [2:0] ack_ctr = '0;
  logic       ack_en;
  logic [8:0] ra;
  assign ack_en   = (ack_ctr != 3'd2) && (ack_ctr != 3'd5);
  assign mem_ack  = mem_req && ack_en;
  assign ra       = {mem_addr[8:2], 2'b00};
  assign mem_rdata = {mem[ra + 9'd3], mem[ra + 9'd2], mem[ra + 9'd1], mem[ra]};

  always @(posedge clk) begin
    ack_ctr <= ack_ctr + 3'd1;
    if (mem_req && mem_ack && mem_we)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[ra + 9'(b)] <= mem_wdata[8*b +: 8];
  end

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // request-hold monitor at the falling edge
  int          hold_bad = 0;
  logic        pend = 1'b0;
  logic [31:0] pend_addr = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend && !(mem_req && mem_addr == pend_addr)) hold_bad++;
      pend      <= mem_req && !mem_ack;
      pend_addr <= mem_addr;
    end
  end

  localparam logic [31:0] BASE = 32'h100;
  localparam int          LENS [4] = '{8, 8, 4, 16};
  localparam logic [31:0] BUFS [4] = '{32'h000, 32'h040, 32'h080, 32'h0C0};

  function automatic logic [31:0] get32(input logic [31:0] a);
    return {mem[a[8:0] + 9'd3], mem[a[8:0] + 9'd2], mem[a[8:0] + 9'd1], mem[a[8:0]]};
  endfunction

  task automatic put32(input logic [31:0] a, input logic [31:0] v);
    for (int b = 0; b < 4; b++) mem[a[8:0] + 9'(b)] = v[8*b +: 8];
  endtask

  function automatic logic [31:0] armed_w0(input int i);
    logic [31:0] w;
    w = 32'h8000_0000 | 32'(LENS[i]);
    if (i == 3) w[30] = 1'b1;
    return w;
  endfunction

  task automatic arm_all();
    for (int i = 0; i < 4; i++) begin
      put32(BASE + 32'(8 * i), armed_w0(i));
      put32(BASE + 32'(8 * i) + 32'd4, BUFS[i]);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  int first_wait;
  task automatic send_pkt(input int len, input int seed);
    first_wait = 0;
    for (int i = 0; i < len; i++) begin
      bit hs;
      hs = 1'b0;
      while (!hs) begin
        @(negedge clk);
        s_valid = 1'b1;
        s_data  = 8'(seed + i);
        s_last  = (i == len - 1);
        #1 hs = s_ready;
        @(posedge clk);
        if (i == 0) first_wait++;
      end
    end
    @(negedge clk);
    s_valid = 1'b0;
    s_last  = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  // vector: {packet length, descriptors used, next descriptor index}
  localparam logic [23:0] VEC [6] = '{
    {8'd5,  8'd1, 8'd1},
    {8'd8,  8'd1, 8'd2},
    {8'd10, 8'd2, 8'd0},
    {8'd20, 8'd3, 8'd3},
    {8'd1,  8'd1, 8'd0},
    {8'd30, 8'd4, 8'd0}
  };

  logic [31:0] rd;
  int          cur_idx;

  initial begin
    #600000;
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'hEE;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    reg_read(8'h04, rd); chk(rd == 0, "R1 base reset", rd, 0);
    reg_read(8'h08, rd); chk(rd == 0, "R1 current reset", rd, 0);
    chk(drop_cnt == 0, "R7 drop reset", 32'(drop_cnt), 0);
    chk(!s_ready && !mem_req, "R9 idle outputs", {s_ready, mem_req}, 0);

    reg_write(8'h04, BASE);
    reg_write(8'h08, BASE);
    reg_read(8'h04, rd); chk(rd == BASE, "R1 base write", rd, BASE);
    reg_read(8'h08, rd); chk(rd == BASE, "R1 current write", rd, BASE);
    reg_read(8'h0C, rd); chk(rd == 0, "R1 unknown offset", rd, 0);

    cur_idx = 0;
    for (int v = 0; v < 6; v++) begin
      int len, used, nxt, rem, k, seed;
      len  = int'(VEC[v][23:16]);
      used = int'(VEC[v][15:8]);
      nxt  = int'(VEC[v][7:0]);
      seed = v * 37;
      arm_all();
      send_pkt(len, seed);
      if (v == 0) chk(first_wait >= 4, "R9 first byte held during fetch", first_wait, 4);
      rem = len; k = 0;
      while (rem > 0) begin
        int idx, take, bad;
        logic [31:0] exp0, got0;
        idx  = (cur_idx + k) % 4;
        take = (LENS[idx] < rem) ? LENS[idx] : rem;
        rem -= take;
        exp0 = armed_w0(idx);
        exp0[31] = 1'b0;
        exp0[27] = (rem > 0);
        exp0[12:0] = 13'(take);
        got0 = get32(BASE + 32'(8 * idx));
        chk(got0 == exp0, "R5 write-back word0", got0, exp0);
        got0 = get32(BASE + 32'(8 * idx) + 32'd4);
        chk(got0 == BUFS[idx], "R2 word1 untouched", got0, BUFS[idx]);
        bad = 0;
        for (int b = 0; b < take; b++)
          if (mem[BUFS[idx][8:0] + 9'(b)] != 8'(seed + (len - rem - take) + b)) bad++;
        chk(bad == 0, "R3 buffer bytes", bad, 0);
        k++;
      end
      chk(k == used, "R4 descriptors used", k, used);
      reg_read(8'h08, rd);
      chk(rd == BASE + 32'(8 * nxt), "R6 R4 next pointer", rd, BASE + 32'(8 * nxt));
      cur_idx = nxt;
    end
    chk(drop_cnt == 0, "R7 no drops in table", 32'(drop_cnt), 0);

    // unowned first descriptor: whole packet dropped
    arm_all();
    put32(BASE, 32'h0000_0008);
    mem[0] = 8'hEE;
    send_pkt(6, 8'h50);
    chk(drop_cnt == 1, "R7 drop count", 32'(drop_cnt), 1);
    reg_read(8'h08, rd); chk(rd == BASE, "R7 pointer unchanged", rd, BASE);
    rd = get32(BASE); chk(rd == 32'h8, "R7 descriptor untouched", rd, 32'h8);
    chk(mem[0] == 8'hEE, "R7 buffer untouched", 32'(mem[0]), 32'hEE);

    // unowned chained descriptor: truncation
    arm_all();
    put32(BASE + 32'd8, 32'h0000_0008);
    mem[9'h040] = 8'hEE;
    send_pkt(12, 8'h70);
    rd = get32(BASE); chk(rd == 32'h0000_0008, "R8 first write-back", rd, 32'h8);
    reg_read(8'h08, rd); chk(rd == BASE + 32'd8, "R8 pointer at unowned", rd, BASE + 32'd8);
    chk(drop_cnt == 2, "R8 drop count", 32'(drop_cnt), 2);
    chk(mem[9'h040] == 8'hEE, "R8 second buffer untouched", 32'(mem[9'h040]), 32'hEE);
    chk(mem[9'h007] == 8'h77, "R8 stored part kept", 32'(mem[9'h007]), 32'h77);

    chk(hold_bad == 0, "R10 request hold", hold_bad, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule